// File: doc/BRIEF.md
# ATM Cell Flag Controller for a 16-bit Cell Bus

This block drives the two availability handshakes of one ATM channel on a 16-bit cell bus. One handshake tells the ATM layer that a receive cell is waiting. The other tells it that the transmit FIFO can take another cell. The block follows the words that cross the bus in each direction, and it compares the cell counts reported by the FIFO with their thresholds. From this it decides when each flag rises and when it falls. The FIFO storage, the header checksum and address polling are outside the block.

A cell is 26 bus words. When the header-checksum slot is enabled, one dummy word follows the header and the cell is 27 words. At the first word of a cell the block records whether that cell is the final one. For receive, that means the final buffered cell. For transmit, it means the final cell the programmed depth limit allows. For a final cell, the flag falls one word after the programmed payload byte has crossed, so the far side learns about the stall early. Between cells the flag follows the FIFO counts.

The block also sets the polarity of both flags, selects a response latency of one or two cycles, generates receive parity and checks transmit parity. It supports normal burst mode and pass-through mode.

Top module: `utopia_cell_flags`

## Requirements
- R1: When no receive cell is in progress, the internal receive flag takes the value (rx_cells != 0) at each clock edge. Reset clears both internal flags.
- R2: Once a cell has started, neither flag rises until its last word has crossed. The last word is word 25, or word 26 when cfg_hec_slot=1, with words numbered from 0. At the next edge after that, the flag is recomputed from the counts.
- R3: A receive cell whose start found rx_cells == 1 drops the receive flag at the edge that transfers payload byte k = cfg_rx_mark (1..48). That byte lies in word 2 + (k-1)/2 (integer division), plus 1 when cfg_hec_slot=1.
- R4: A transmit cell whose start found tx_cells == cfg_tx_limit - 1 drops the space flag at the edge that transfers the word carrying payload byte cfg_tx_mark (9..48). The same word mapping as R3 applies.
- R5: Between cells, the space flag is high exactly when tx_cells < cfg_tx_limit. The limit ranges from 1 to 64.
- R6: With cfg_flag_low=1, both pins are inverted, so a low pin means the flag is asserted. With cfg_flag_low=0, a high pin means the flag is asserted.
- R7: rx_par makes the number of ones in {rx_data, rx_par} odd when cfg_par_even=0 and even when cfg_par_even=1.
- R8: tx_par_err is high in the cycle after a transferred transmit word whose parity breaks the rule in R7. A word that is not transferred never raises tx_par_err.
- R9: With cfg_resp2=0, each pin shows the internal flag from the same edge. With cfg_resp2=1, each pin lags the internal flag by one more cycle.
- R10: In normal mode (cfg_passthru=0), a strobe is sampled only at word 0, and a receive cell starts only when rx_cells != 0. After the start, words advance every cycle. In pass-through mode, a word advances only in a cycle with its strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hec_slot | input | 1 | 1: a dummy word follows the header (27-word cell) |
| cfg_passthru | input | 1 | 1: pass-through mode; 0: normal burst mode |
| cfg_par_even | input | 1 | Parity sense: 0 odd, 1 even |
| cfg_resp2 | input | 1 | 1: two-cycle response latency |
| cfg_flag_low | input | 1 | 1: flags asserted low |
| cfg_rx_mark | input | 6 | Receive early-drop payload byte, 1..48 |
| cfg_tx_mark | input | 6 | Transmit early-drop payload byte, 9..48 |
| cfg_tx_limit | input | 7 | Transmit FIFO depth limit in cells, 1..64 |
| rx_cells | input | 7 | Complete cells in the receive FIFO, counting the cell being read |
| rx_take | input | 1 | Receive enable from the ATM layer |
| rx_data | input | 16 | Receive word on the bus |
| rx_par | output | 1 | Generated parity for rx_data |
| rx_cell_avail | output | 1 | Receive cell-available pin |
| tx_cells | input | 7 | Complete cells held in the transmit FIFO |
| tx_put | input | 1 | Transmit enable from the ATM layer |
| tx_data | input | 16 | Transmit word on the bus |
| tx_par | input | 1 | Parity bit sent with tx_data |
| tx_space_avail | output | 1 | Transmit space-available pin |
| tx_par_err | output | 1 | Parity error on the previous transferred transmit word |

## Verification
The assertions assume that the configuration inputs change only while no cell is in progress in either direction. Under that assumption, the word index never passes the last word of the current format. They also assume that the mark bytes and the depth limit stay within their stated ranges. The bench changes configuration only between cells and completes every cell it starts. It also keeps every mark and limit inside its legal range, so the stimulus never leaves the region the assertions cover.

// File: rtl/utcf_pkg.sv
package utcf_pkg;
  localparam int unsigned BUS_W      = 16;
  localparam int unsigned BPW        = BUS_W / 8;
  localparam int unsigned CELL_BYTES = 52;
  localparam int unsigned HDR_BYTES  = 4;
  localparam int unsigned BASE_WORDS = CELL_BYTES / BPW;
  localparam int unsigned HDR_WORDS  = HDR_BYTES / BPW;
  localparam int unsigned WIDX_W     = $clog2(BASE_WORDS + 1);

  typedef logic [WIDX_W-1:0] widx_t;

  // Index of the last word of a cell for the selected format.
  function automatic widx_t last_word(input logic hec);
    int unsigned n;
    n = BASE_WORDS + (hec ? 1 : 0) - 1;
    return widx_t'(n);
  endfunction

  // Index of the word that carries payload byte k (1-based).
  function automatic widx_t mark_word(input logic hec, input logic [5:0] k);
    int unsigned n;
    n = HDR_WORDS + (hec ? 1 : 0) + (int'(k) - 1) / BPW;
    return widx_t'(n);
  endfunction
endpackage

// File: rtl/utcf_wordctr.sv
module utcf_wordctr
  import utcf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  logic  have,
  input  logic  passthru,
  input  widx_t lastw,
  output logic  xfer,
  output logic  busy,
  output widx_t widx
);
  widx_t widx_q, widx_n;
  logic  busy_q, busy_n;

  always_comb begin
    if (passthru) xfer = strobe && (busy_q || have);
    else          xfer = busy_q || (strobe && have);
    widx_n = widx_q;
    busy_n = busy_q;
    if (xfer) begin
      if (widx_q == lastw) begin
        widx_n = '0;
        busy_n = 1'b0;
      end else begin
        widx_n = widx_q + widx_t'(1);
        busy_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      busy_q <= 1'b0;
    end else if (xfer) begin
      widx_q <= widx_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
  assign widx = widx_q;
endmodule

// File: rtl/utcf_flagctl.sv
module utcf_flagctl
  import utcf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  xfer,
  input  logic  busy,
  input  widx_t widx,
  input  widx_t markw,
  input  logic  avail_now,
  input  logic  last_now,
  output logic  flag
);
  logic flag_q, flag_n;
  logic fin_q, fin_n;
  logic cap_en;

  assign cap_en = xfer && (widx == '0);

  always_comb begin
    fin_n  = cap_en ? last_now : fin_q;
    flag_n = flag_q;
    if (!busy)
      flag_n = avail_now;
    else if (xfer && fin_q && (widx == markw))
      flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      if (cap_en) fin_q <= fin_n;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/utcf_outstage.sv
module utcf_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic resp2,
  input  logic act_low,
  output logic pin
);
  logic lag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lag_q <= 1'b0;
    else        lag_q <= flag;
  end

  assign pin = (resp2 ? lag_q : flag) ^ act_low;
endmodule

// File: rtl/utcf_parity.sv
module utcf_parity #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         even,
  input  logic [W-1:0] rx_data,
  output logic         rx_par,
  input  logic [W-1:0] tx_data,
  input  logic         tx_par,
  input  logic         tx_xfer,
  output logic         tx_err
);
  logic err_q, err_n;

  assign rx_par = (^rx_data) ^ ~even;

  always_comb begin
    err_n = tx_xfer && (((^tx_data) ^ tx_par) == even);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  assign tx_err = err_q;
endmodule

// File: rtl/utopia_cell_flags.sv
module utopia_cell_flags
  import utcf_pkg::*;
#(
  parameter int unsigned MAX_CELLS = 64,
  localparam int unsigned CNT_W    = $clog2(MAX_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hec_slot,
  input  logic              cfg_passthru,
  input  logic              cfg_par_even,
  input  logic              cfg_resp2,
  input  logic              cfg_flag_low,
  input  logic [5:0]        cfg_rx_mark,
  input  logic [5:0]        cfg_tx_mark,
  input  logic [CNT_W-1:0]  cfg_tx_limit,
  input  logic [CNT_W-1:0]  rx_cells,
  input  logic              rx_take,
  input  logic [BUS_W-1:0]  rx_data,
  output logic              rx_par,
  output logic              rx_cell_avail,
  input  logic [CNT_W-1:0]  tx_cells,
  input  logic              tx_put,
  input  logic [BUS_W-1:0]  tx_data,
  input  logic              tx_par,
  output logic              tx_space_avail,
  output logic              tx_par_err
);
  widx_t lastw, rx_markw, tx_markw;
  widx_t rx_widx, tx_widx;
  logic  rx_xfer, rx_busy, rx_flag, rx_have, rx_last;
  logic  tx_xfer, tx_busy, tx_flag, tx_avail, tx_last;

  assign lastw    = last_word(cfg_hec_slot);
  assign rx_markw = mark_word(cfg_hec_slot, cfg_rx_mark);
  assign tx_markw = mark_word(cfg_hec_slot, cfg_tx_mark);

  assign rx_have  = (rx_cells != '0);
  assign rx_last  = (rx_cells == CNT_W'(1));
  assign tx_avail = (tx_cells < cfg_tx_limit);
  assign tx_last  = (tx_cells == (cfg_tx_limit - CNT_W'(1)));

  utcf_wordctr u_rx_ctr (
    .clk(clk), .rst_n(rst_n), .strobe(rx_take), .have(rx_have),
    .passthru(cfg_passthru), .lastw(lastw),
    .xfer(rx_xfer), .busy(rx_busy), .widx(rx_widx)
  );

  utcf_flagctl u_rx_flag (
    .clk(clk), .rst_n(rst_n), .xfer(rx_xfer), .busy(rx_busy),
    .widx(rx_widx), .markw(rx_markw), .avail_now(rx_have),
    .last_now(rx_last), .flag(rx_flag)
  );

  utcf_wordctr u_tx_ctr (
    .clk(clk), .rst_n(rst_n), .strobe(tx_put), .have(1'b1),
    .passthru(cfg_passthru), .lastw(lastw),
    .xfer(tx_xfer), .busy(tx_busy), .widx(tx_widx)
  );

  utcf_flagctl u_tx_flag (
    .clk(clk), .rst_n(rst_n), .xfer(tx_xfer), .busy(tx_busy),
    .widx(tx_widx), .markw(tx_markw), .avail_now(tx_avail),
    .last_now(tx_last), .flag(tx_flag)
  );

  utcf_outstage u_rx_out (
    .clk(clk), .rst_n(rst_n), .flag(rx_flag), .resp2(cfg_resp2),
    .act_low(cfg_flag_low), .pin(rx_cell_avail)
  );

  utcf_outstage u_tx_out (
    .clk(clk), .rst_n(rst_n), .flag(tx_flag), .resp2(cfg_resp2),
    .act_low(cfg_flag_low), .pin(tx_space_avail)
  );

  utcf_parity #(.W(BUS_W)) u_par (
    .clk(clk), .rst_n(rst_n), .even(cfg_par_even),
    .rx_data(rx_data), .rx_par(rx_par),
    .tx_data(tx_data), .tx_par(tx_par), .tx_xfer(tx_xfer),
    .tx_err(tx_par_err)
  );
endmodule

// File: rtl/utcf_checker.sv
module utcf_checker
  import utcf_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hec_slot,
  input logic             cfg_resp2,
  input logic             cfg_flag_low,
  input logic [CNT_W-1:0] cfg_tx_limit,
  input logic [CNT_W-1:0] rx_cells,
  input logic [CNT_W-1:0] tx_cells,
  input logic             rx_busy,
  input logic             rx_flag,
  input logic             tx_busy,
  input logic             tx_flag,
  input logic             tx_xfer,
  input widx_t            rx_widx,
  input logic             rx_cell_avail,
  input logic             tx_par_err
);
  a_r1_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_busy |=> (rx_flag == ($past(rx_cells) != '0)));

  a_r2_rx_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> (!rx_flag || $past(rx_flag)));

  a_r2_tx_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> (!tx_flag || $past(tx_flag)));

  a_r2_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_widx <= last_word(cfg_hec_slot));

  a_r5_tx_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && (tx_cells >= cfg_tx_limit)) |=> !tx_flag);

  a_r6_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_resp2 |-> (rx_cell_avail == (rx_flag ^ cfg_flag_low)));

  a_r9_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_resp2 && $past(cfg_resp2)) |-> (rx_cell_avail == ($past(rx_flag) ^ cfg_flag_low)));

  a_r8_err_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_par_err |-> $past(tx_xfer));
endmodule

bind utopia_cell_flags utcf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hec_slot(cfg_hec_slot),
  .cfg_resp2(cfg_resp2), .cfg_flag_low(cfg_flag_low),
  .cfg_tx_limit(cfg_tx_limit), .rx_cells(rx_cells), .tx_cells(tx_cells),
  .rx_busy(rx_busy), .rx_flag(rx_flag), .tx_busy(tx_busy),
  .tx_flag(tx_flag), .tx_xfer(tx_xfer), .rx_widx(rx_widx),
  .rx_cell_avail(rx_cell_avail), .tx_par_err(tx_par_err)
);

// File: tb/tb_utopia_cell_flags.sv
module tb_utopia_cell_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_hec_slot, cfg_passthru, cfg_par_even, cfg_resp2, cfg_flag_low;
  logic [5:0]  cfg_rx_mark, cfg_tx_mark;
  logic [6:0]  cfg_tx_limit, rx_cells, tx_cells;
  logic        rx_take, tx_put, tx_par;
  logic [15:0] rx_data, tx_data;
  logic        rx_par, rx_cell_avail, tx_space_avail, tx_par_err;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {data, even, expected parity bit}
  localparam logic [17:0] PVEC [8] = '{
    {16'h0000, 1'b0, 1'b1},
    {16'hFFFF, 1'b1, 1'b0},
    {16'h0001, 1'b0, 1'b0},
    {16'h0001, 1'b1, 1'b1},
    {16'h1234, 1'b0, 1'b0},
    {16'h00FF, 1'b1, 1'b0},
    {16'h0007, 1'b1, 1'b1},
    {16'hA5A5, 1'b0, 1'b1}
  };

  utopia_cell_flags dut (
    .clk(clk), .rst_n(rst_n), .cfg_hec_slot(cfg_hec_slot),
    .cfg_passthru(cfg_passthru), .cfg_par_even(cfg_par_even),
    .cfg_resp2(cfg_resp2), .cfg_flag_low(cfg_flag_low),
    .cfg_rx_mark(cfg_rx_mark), .cfg_tx_mark(cfg_tx_mark),
    .cfg_tx_limit(cfg_tx_limit), .rx_cells(rx_cells), .rx_take(rx_take),
    .rx_data(rx_data), .rx_par(rx_par), .rx_cell_avail(rx_cell_avail),
    .tx_cells(tx_cells), .tx_put(tx_put), .tx_data(tx_data),
    .tx_par(tx_par), .tx_space_avail(tx_space_avail), .tx_par_err(tx_par_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_hec_slot = 1'b0; cfg_passthru = 1'b1; cfg_par_even = 1'b0;
    cfg_resp2 = 1'b0; cfg_flag_low = 1'b0;
    cfg_rx_mark = 6'd48; cfg_tx_mark = 6'd48; cfg_tx_limit = 7'd4;
    rx_cells = '0; tx_cells = '0; rx_take = 1'b0; tx_put = 1'b0;
    rx_data = '0; tx_data = '0; tx_par = 1'b1;
    #10;
    chk("R1 reset rx pin", rx_cell_avail, 1'b0);
    chk("R1 reset tx pin", tx_space_avail, 1'b0);
    chk("R8 reset err", tx_par_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R5 space after reset", tx_space_avail, 1'b1);
    chk("R1 empty rx", rx_cell_avail, 1'b0);

    // Parity table, pass-through mode, each word transferred
    for (int i = 0; i < 8; i++) begin
      cfg_par_even = PVEC[i][1];
      rx_data = PVEC[i][17:2];
      tx_data = PVEC[i][17:2];
      #1;
      chk("R7 rx parity", rx_par, PVEC[i][0]);
      tx_par = PVEC[i][0]; tx_put = 1'b1;
      step();
      chk("R8 good word no error", tx_par_err, 1'b0);
      tx_par = ~PVEC[i][0];
      step();
      chk("R8 bad word flagged", tx_par_err, 1'b1);
    end
    tx_put = 1'b0; tx_par = 1'b0; tx_data = 16'h0000; cfg_par_even = 1'b0;
    step();
    chk("R8 idle bad word ignored", tx_par_err, 1'b0);
    tx_par = 1'b1; tx_put = 1'b1;
    steps(10);
    tx_put = 1'b0;
    cfg_passthru = 1'b0;
    step();

    // R1 follow counts
    rx_cells = 7'd2; step(); chk("R1 rx cells 2", rx_cell_avail, 1'b1);
    rx_cells = 7'd0; step(); chk("R1 rx cells 0", rx_cell_avail, 1'b0);

    // R10 enable with empty FIFO starts nothing
    rx_take = 1'b1; step(); rx_take = 1'b0; rx_cells = 7'd1;
    step(); chk("R10 no start when empty", rx_cell_avail, 1'b1);

    // R3 early drop at byte 5 (word 4), no HEC slot
    cfg_rx_mark = 6'd5;
    rx_take = 1'b1; step(); rx_take = 1'b0;
    steps(3); chk("R3 before mark word", rx_cell_avail, 1'b1);
    step();   chk("R3 drop after word 4", rx_cell_avail, 1'b0);
    steps(21); chk("R2 held through word 25", rx_cell_avail, 1'b0);
    step();   chk("R2 recompute after 26 words", rx_cell_avail, 1'b1);

    // R2 non-final cell holds despite count change
    rx_cells = 7'd3; step();
    rx_take = 1'b1; step(); rx_take = 1'b0; rx_cells = 7'd0;
    steps(25); chk("R2 hold in cell", rx_cell_avail, 1'b1);
    step();    chk("R2 follow after cell", rx_cell_avail, 1'b0);

    // R3 with HEC slot, byte 48 is word 26 (last)
    cfg_hec_slot = 1'b1; cfg_rx_mark = 6'd48; rx_cells = 7'd1; step();
    rx_take = 1'b1; step(); rx_take = 1'b0;
    steps(25); chk("R3 hec before last word", rx_cell_avail, 1'b1);
    step();    chk("R3 hec drop at word 26", rx_cell_avail, 1'b0);
    step();    chk("R2 hec 27-word cell ends", rx_cell_avail, 1'b1);
    cfg_hec_slot = 1'b0;

    // R10 pass-through: words advance only with enable; byte 1 in word 2
    cfg_passthru = 1'b1; cfg_rx_mark = 6'd1; step();
    rx_take = 1'b1; step();
    rx_take = 1'b0; step();
    rx_take = 1'b1; step();
    rx_take = 1'b0; steps(2); chk("R10 pass-through stalls", rx_cell_avail, 1'b1);
    rx_take = 1'b1; step();  chk("R10 drop on third word", rx_cell_avail, 1'b0);
    steps(23); rx_take = 1'b0; rx_cells = 7'd0;
    step(); chk("R10 idle after cell", rx_cell_avail, 1'b0);
    rx_cells = 7'd1;
    step(); chk("R10 follows count again", rx_cell_avail, 1'b1);
    cfg_passthru = 1'b0; rx_cells = 7'd0; step();

    // R4 transmit early drop, byte 9 in word 6
    cfg_tx_mark = 6'd9; tx_cells = 7'd3; step();
    chk("R5 below limit", tx_space_avail, 1'b1);
    tx_put = 1'b1; step(); tx_put = 1'b0;
    steps(5); chk("R4 before mark", tx_space_avail, 1'b1);
    step();   chk("R4 drop after word 6", tx_space_avail, 1'b0);
    steps(19); chk("R2 tx held", tx_space_avail, 1'b0);
    tx_cells = 7'd4;
    step(); chk("R5 at limit", tx_space_avail, 1'b0);
    tx_cells = 7'd2;
    step(); chk("R5 below limit again", tx_space_avail, 1'b1);

    // R4 boundary: limit 1, HEC slot, byte 48
    cfg_tx_limit = 7'd1; cfg_hec_slot = 1'b1; cfg_tx_mark = 6'd48; tx_cells = 7'd0;
    step(); chk("R5 limit 1 empty", tx_space_avail, 1'b1);
    tx_put = 1'b1; step(); tx_put = 1'b0;
    steps(25); chk("R4 limit1 before last", tx_space_avail, 1'b1);
    step();    chk("R4 limit1 drop word 26", tx_space_avail, 1'b0);
    tx_cells = 7'd1;
    step(); chk("R5 limit 1 full", tx_space_avail, 1'b0);
    tx_cells = 7'd0;
    step(); chk("R5 limit 1 drained", tx_space_avail, 1'b1);
    cfg_hec_slot = 1'b0;

    // R5 boundary at 64
    cfg_tx_limit = 7'd64; tx_cells = 7'd63;
    step(); chk("R5 63 of 64", tx_space_avail, 1'b1);
    tx_cells = 7'd64;
    step(); chk("R5 64 of 64", tx_space_avail, 1'b0);
    tx_cells = 7'd0; step();

    // R6 active-low pins
    cfg_flag_low = 1'b1;
    step(); chk("R6 low rx idle", rx_cell_avail, 1'b1);
    chk("R6 low tx asserted", tx_space_avail, 1'b0);
    rx_cells = 7'd2;
    step(); chk("R6 low rx asserted", rx_cell_avail, 1'b0);
    cfg_flag_low = 1'b0; rx_cells = 7'd0; steps(2);

    // R9 two-cycle response
    cfg_resp2 = 1'b1; steps(2);
    chk("R9 settled low", rx_cell_avail, 1'b0);
    rx_cells = 7'd2;
    step(); chk("R9 lag one cycle", rx_cell_avail, 1'b0);
    step(); chk("R9 rises after lag", rx_cell_avail, 1'b1);
    rx_cells = 7'd0;
    step(); chk("R9 fall lags", rx_cell_avail, 1'b1);
    step(); chk("R9 falls", rx_cell_avail, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule